// File: doc/BRIEF.md
# Power-On Reset Release and First Bus Ownership Sequencer

This block controls how a processor's bus interface comes out of power-on reset. It runs on the core clock. The slower bus clock reaches it as a one-cycle enable, `busClkEn`. The active-low reset input and the mode straps count only on cycles where that enable is high.

While reset is sampled low, the block records the strap pins at every bus edge. The value recorded at the last low-sampled edge becomes the latched mode configuration. After release, the internal core reset stays asserted for a fixed stretch of core cycles.

After the stretch, all bus output enables stay off until the bus is granted. When grant is seen at a bus edge and no transfer-start is present, the block takes implicit ownership and pulses a start request once. That pulse opens the first reset-exception bus cycle. If another master's transfer-start is seen first, the block leaves the bus alone until that master's tenure ends. The end is shown either by the tenure-end input or by the busy line falling between two bus edges.

Top module: `boot_bus_seq`

## Requirements
- R1: `rstInN` is acted on only in cycles with `busClkEn`=1. One cycle after such a cycle with `rstInN`=0, the block is in reset: `coreRst`=1, `busOe`=0, `cfgValid`=0 and `startReq`=0. A low `rstInN` in a cycle without `busClkEn` changes nothing at the outputs.
- R2: Let the release edge be the first bus edge with `rstInN` sampled 1 after a low sample. `coreRst` stays 1 for exactly STRETCH_CYC core cycles after the release edge, with a default of 27. It is 0 from then on.
- R3: `cfg` = {`iplIn`, `dataIn`}, with `iplIn` in the upper 3 bits. The value is the one present at the last bus edge with `rstInN` sampled 0. Strap values present only in cycles without `busClkEn`, or at the release edge, are not taken. `cfgValid` is 1 from the cycle after the release edge.
- R4: While `cfgValid`=1, `cfg` holds its value whatever the strap inputs do, until reset is next sampled low.
- R5: While `coreRst`=1, `busOe` is all zero. After the stretch, `busOe` stays all zero and no start is issued while `busGnt` is 0.
- R6: `startReq` is a single-cycle pulse. It occurs only in a `busClkEn` cycle, and only at the first bus edge after the stretch with `busGnt`=1 and `xferStartIn`=0. It is issued at most once per reset sequence.
- R7: `busOe` goes to all ones in the same cycle as `startReq`. It stays all ones until reset is next sampled low.
- R8: If `xferStartIn`=1 at a bus edge while the block waits for the bus, no start is issued even with grant present. The wait ends at a bus edge with `tenureEnd`=1, or at a bus edge with `busBusy`=0 when the previous bus edge sampled `busBusy`=1.
- R9: The bus edge that ends an alternate tenure never issues a start, even if `busGnt`=1 at that edge. The earliest start is at the next bus edge.
- R10: A low reset sampled while waiting for grant or after ownership suppresses any start in that cycle. It returns the block to R1's reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| busClkEn | input | 1 | One-cycle enable marking a rising bus-clock edge |
| rstInN | input | 1 | Active-low reset request, sampled on bus edges |
| busGnt | input | 1 | Bus grant, active high |
| xferStartIn | input | 1 | Transfer start seen on the bus, active high |
| tenureEnd | input | 1 | Alternate master's tenure finished, active high |
| busBusy | input | 1 | Bus busy, active high |
| iplIn | input | 3 | Interrupt-level strap pins |
| dataIn | input | 16 | Low data-bus strap pins |
| coreRst | output | 1 | Internal core reset, active high |
| cfg | output | 19 | Latched mode configuration {iplIn, dataIn} |
| cfgValid | output | 1 | Configuration has been captured |
| busOe | output | 4 | Output enables for the bus output groups |
| startReq | output | 1 | One-cycle request to begin the first bus cycle |

## Verification
An alternate tenure can end at the same bus edge where grant is present. In that case the tenure exit and the ownership decision compete for one cycle. The bench provokes this twice: once with `tenureEnd` and grant together, and once with a falling busy line while grant is held. In both it requires `startReq` low at that edge and high at the next one. A reset sample can likewise land on an edge where grant would otherwise start the bus. That edge is checked for a suppressed pulse and for a return to reset with no start counted.

// File: rtl/boot_bus_pkg.sv
package boot_bus_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_STRETCH = 3'd1,
    ST_WAITGNT = 3'd2,
    ST_ALT     = 3'd3,
    ST_OWN     = 3'd4
  } seqState_t;

  typedef struct packed {
    logic busEdge;
    logic shadowEn;
    logic loadCfg;
    logic clearCfg;
    logic driveBus;
  } dpStrobe_t;

endpackage

// File: rtl/boot_bus_ctrl.sv
module boot_bus_ctrl
  import boot_bus_pkg::*;
#(
  parameter int STRETCH_CYC = 27
) (
  input  logic      clk,
  input  logic      busClkEn,
  input  logic      rstInN,
  input  logic      busGnt,
  input  logic      xferStartIn,
  input  logic      tenureEnd,
  input  logic      busyFell,
  output dpStrobe_t strobe,
  output logic      coreRst,
  output logic      startReq
);

  localparam int CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_CYC - 1);

  seqState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic resetSample, releaseSample, startNow;

  always_comb begin
    resetSample   = busClkEn && !rstInN;
    releaseSample = busClkEn && rstInN;
    startNow      = 1'b0;
    stateD        = stateQ;
    case (stateQ)
      ST_HOLD: begin
        if (releaseSample) stateD = ST_STRETCH;
      end
      ST_STRETCH: begin
        if (cntQ == CNT_LAST) stateD = ST_WAITGNT;
      end
      ST_WAITGNT: begin
        if (releaseSample) begin
          if (xferStartIn) begin
            stateD = ST_ALT;
          end else if (busGnt) begin
            stateD   = ST_OWN;
            startNow = 1'b1;
          end
        end
      end
      ST_ALT: begin
        if (releaseSample && (tenureEnd || busyFell)) stateD = ST_WAITGNT;
      end
      ST_OWN:  stateD = ST_OWN;
      default: stateD = ST_HOLD;
    endcase
    if (resetSample) stateD = ST_HOLD;
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
    if (stateQ != ST_STRETCH) cntQ <= '0;
    else                      cntQ <= cntQ + 1'b1;
  end

  always_comb begin
    strobe.busEdge  = busClkEn;
    strobe.shadowEn = resetSample;
    strobe.loadCfg  = (stateQ == ST_HOLD) && releaseSample;
    strobe.clearCfg = resetSample;
    strobe.driveBus = (stateQ == ST_OWN) || startNow;
    coreRst         = (stateQ == ST_HOLD) || (stateQ == ST_STRETCH);
    startReq        = startNow;
  end

  // R2: the stretch counter never runs past its limit
  a_r2_stretch_bound: assert property (@(posedge clk) disable iff (!rstInN)
    (stateQ == ST_STRETCH) |-> (cntQ < CNT_W'(STRETCH_CYC)));

  // R2: the last stretch cycle releases the core reset
  a_r2_stretch_exit: assert property (@(posedge clk) disable iff (!rstInN)
    (stateQ == ST_STRETCH && cntQ == CNT_LAST && !busClkEn) |=> !coreRst);

  // R6: start only on a bus edge with grant and no foreign transfer
  a_r6_start_on_edge: assert property (@(posedge clk) disable iff (!rstInN)
    startReq |-> (busClkEn && busGnt && !xferStartIn));

  // R6: the start request lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstInN)
    startReq |=> !startReq);

  // R8: a foreign tenure is left only at a bus edge
  a_r8_alt_hold: assert property (@(posedge clk) disable iff (!rstInN)
    (stateQ == ST_ALT && !busClkEn) |=> (stateQ == ST_ALT));

endmodule

// File: rtl/boot_bus_dp.sv
module boot_bus_dp
  import boot_bus_pkg::*;
#(
  parameter int IPL_W = 3,
  parameter int DAT_W = 16,
  parameter int OE_W  = 4
) (
  input  logic                   clk,
  input  dpStrobe_t              strobe,
  input  logic [IPL_W-1:0]       iplIn,
  input  logic [DAT_W-1:0]       dataIn,
  input  logic                   busBusy,
  output logic [IPL_W+DAT_W-1:0] cfg,
  output logic                   cfgValid,
  output logic                   busyFell,
  output logic [OE_W-1:0]        busOe
);

  localparam int CFG_W = IPL_W + DAT_W;

  logic [CFG_W-1:0] shadowQ, cfgQ;
  logic             validQ, busyQ;

  always_ff @(posedge clk) begin
    if (strobe.shadowEn) shadowQ <= {iplIn, dataIn};
    if (strobe.busEdge)  busyQ   <= busBusy;
    if (strobe.clearCfg) begin
      validQ <= 1'b0;
    end else if (strobe.loadCfg) begin
      cfgQ   <= shadowQ;
      validQ <= 1'b1;
    end
  end

  assign busyFell = busyQ && !busBusy;
  assign cfg      = cfgQ;
  assign cfgValid = validQ;

  for (genvar g = 0; g < OE_W; g++) begin : g_oe
    assign busOe[g] = strobe.driveBus;
  end

  // R4: captured configuration holds until the next reset sample
  a_r4_cfg_stable: assert property (@(posedge clk) disable iff (strobe.clearCfg)
    (validQ && $past(validQ)) |-> $stable(cfgQ));

endmodule

// File: rtl/boot_bus_seq.sv
module boot_bus_seq
  import boot_bus_pkg::*;
#(
  parameter int STRETCH_CYC = 27,
  parameter int IPL_W       = 3,
  parameter int DAT_W       = 16,
  parameter int OE_W        = 4
) (
  input  logic                   clk,
  input  logic                   busClkEn,
  input  logic                   rstInN,
  input  logic                   busGnt,
  input  logic                   xferStartIn,
  input  logic                   tenureEnd,
  input  logic                   busBusy,
  input  logic [IPL_W-1:0]       iplIn,
  input  logic [DAT_W-1:0]       dataIn,
  output logic                   coreRst,
  output logic [IPL_W+DAT_W-1:0] cfg,
  output logic                   cfgValid,
  output logic [OE_W-1:0]        busOe,
  output logic                   startReq
);

  dpStrobe_t strobe;
  logic      busyFell;

  boot_bus_ctrl #(.STRETCH_CYC(STRETCH_CYC)) i_ctrl (
    .clk        (clk),
    .busClkEn   (busClkEn),
    .rstInN     (rstInN),
    .busGnt     (busGnt),
    .xferStartIn(xferStartIn),
    .tenureEnd  (tenureEnd),
    .busyFell   (busyFell),
    .strobe     (strobe),
    .coreRst    (coreRst),
    .startReq   (startReq)
  );

  boot_bus_dp #(.IPL_W(IPL_W), .DAT_W(DAT_W), .OE_W(OE_W)) i_dp (
    .clk     (clk),
    .strobe  (strobe),
    .iplIn   (iplIn),
    .dataIn  (dataIn),
    .busBusy (busBusy),
    .cfg     (cfg),
    .cfgValid(cfgValid),
    .busyFell(busyFell),
    .busOe   (busOe)
  );

  // R5: no bus drive while the core is held in reset
  a_r5_oe_off_in_reset: assert property (@(posedge clk) disable iff (!rstInN)
    coreRst |-> (busOe == '0));

  // R7: bus enables come on only together with the start request
  a_r7_oe_with_start: assert property (@(posedge clk) disable iff (!rstInN)
    $rose(busOe[0]) |-> startReq);

endmodule

// File: tb/test_boot_bus_seq.sv
module test_boot_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_RATIO  = 2;
  localparam int STRETCH    = 27;
  localparam int IPL_W      = 3;
  localparam int DAT_W      = 16;
  localparam int OE_W       = 4;
  localparam int CFG_W      = IPL_W + DAT_W;

  logic clk = 0;
  logic busClkEn = 0;
  logic rstInN = 0;
  logic busGnt = 0, xferStartIn = 0, tenureEnd = 0, busBusy = 0;
  logic [IPL_W-1:0] iplIn = '0;
  logic [DAT_W-1:0] dataIn = '0;
  logic coreRst, cfgValid, startReq;
  logic [CFG_W-1:0] cfg;
  logic [OE_W-1:0] busOe;

  int checks = 0, errors = 0, startCnt = 0, divCnt = 0;

  boot_bus_seq #(.STRETCH_CYC(STRETCH), .IPL_W(IPL_W), .DAT_W(DAT_W), .OE_W(OE_W)) i_boot_bus_seq (
    .clk(clk), .busClkEn(busClkEn), .rstInN(rstInN), .busGnt(busGnt),
    .xferStartIn(xferStartIn), .tenureEnd(tenureEnd), .busBusy(busBusy),
    .iplIn(iplIn), .dataIn(dataIn), .coreRst(coreRst), .cfg(cfg),
    .cfgValid(cfgValid), .busOe(busOe), .startReq(startReq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    divCnt   <= (divCnt == BUS_RATIO-1) ? 0 : divCnt + 1;
    busClkEn <= (divCnt == BUS_RATIO-1);
  end

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (startReq === 1'b1) startCnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic toBusEdge();
    do @(negedge clk); while (busClkEn !== 1'b1);
  endtask

  task automatic setStraps(input logic [CFG_W-1:0] v);
    {iplIn, dataIn} = v;
  endtask

  task automatic runReset(input logic [CFG_W-1:0] lowVal);
    rstInN = 0; busGnt = 0; xferStartIn = 0; tenureEnd = 0; busBusy = 0;
    setStraps(lowVal);
    toBusEdge(); toBusEdge(); toBusEdge();
    rstInN = 1;
    repeat (STRETCH + 3) @(negedge clk);
    startCnt = 0;
  endtask

  task automatic testResetState();
    rstInN = 0;
    toBusEdge();
    @(negedge clk); #1;
    check(coreRst === 1'b1, "R1", "coreRst in reset", coreRst, 1);
    check(busOe === '0, "R1", "busOe in reset", busOe, 0);
    check(startReq === 1'b0, "R1", "startReq in reset", startReq, 0);
    check(cfgValid === 1'b0, "R1", "cfgValid in reset", cfgValid, 0);
  endtask

  task automatic testStrapsStretch();
    int n;
    rstInN = 0; busGnt = 0; startCnt = 0;
    toBusEdge(); setStraps(19'h1_2345);
    toBusEdge(); setStraps(19'h5_A5C3);
    @(negedge clk); setStraps(19'h7_FFFF);
    toBusEdge(); rstInN = 1; setStraps(19'h2_0F0F);
    @(negedge clk); #1;
    check(cfg === 19'h5_A5C3, "R3", "cfg from last low edge", cfg, 19'h5_A5C3);
    check(cfgValid === 1'b1, "R3", "cfgValid after release", cfgValid, 1);
    n = 0;
    while (coreRst === 1'b1 && n < 40) begin
      n++;
      @(negedge clk); #1;
    end
    check(n == STRETCH, "R2", "coreRst stretch length", n, STRETCH);
    for (int i = 0; i < 4; i++) begin
      toBusEdge(); #1;
      check(startReq === 1'b0 && busOe === '0, "R5", "no start without grant",
            {startReq, busOe}, 0);
    end
  endtask

  task automatic testGrantStart();
    toBusEdge();
    @(negedge clk); busGnt = 1; #1;
    check(startReq === 1'b0, "R6", "no start off bus edge", startReq, 0);
    toBusEdge(); #1;
    check(startReq === 1'b1, "R6", "start at bus edge with grant", startReq, 1);
    check(busOe === '1, "R7", "busOe with start", busOe, 4'hF);
    @(negedge clk); #1;
    check(startReq === 1'b0, "R6", "start is one cycle", startReq, 0);
    for (int i = 0; i < 4; i++) begin
      toBusEdge(); #1;
      check(busOe === '1, "R7", "busOe held after start", busOe, 4'hF);
    end
    check(startCnt == 1, "R6", "single start count", startCnt, 1);
  endtask

  task automatic testCfgAndReassert();
    for (int i = 0; i < 3; i++) begin
      toBusEdge(); setStraps(CFG_W'(i * 19'h1_1111 + 3));
      @(negedge clk); #1;
      check(cfg === 19'h5_A5C3 && cfgValid === 1'b1, "R4", "cfg held", cfg, 19'h5_A5C3);
    end
    toBusEdge();
    @(negedge clk); rstInN = 0;
    @(negedge clk); #1;
    check(busOe === '1 && coreRst === 1'b0, "R1", "reset ignored off bus edge",
          {coreRst, busOe}, 4'hF);
    @(negedge clk); #1;
    check(busOe === '0 && coreRst === 1'b1, "R10", "reset after ownership",
          {coreRst, busOe}, 5'h10);
    check(cfgValid === 1'b0, "R1", "cfgValid cleared", cfgValid, 0);
  endtask

  task automatic testAltTenure();
    runReset(19'h3_1234);
    check(cfg === 19'h3_1234, "R3", "cfg after second reset", cfg, 19'h3_1234);
    toBusEdge(); xferStartIn = 1; busGnt = 1; #1;
    check(startReq === 1'b0, "R8", "foreign transfer blocks start", startReq, 0);
    toBusEdge(); xferStartIn = 0; #1;
    check(startReq === 1'b0, "R8", "still waiting for tenure", startReq, 0);
    toBusEdge(); busGnt = 0; tenureEnd = 1; #1;
    check(startReq === 1'b0, "R8", "tenure end edge no start", startReq, 0);
    toBusEdge(); tenureEnd = 0; busGnt = 1; #1;
    check(startReq === 1'b1, "R8", "start after tenure end", startReq, 1);
    @(negedge clk);
    check(startCnt == 1, "R8", "start count after tenure", startCnt, 1);
  endtask

  task automatic testAltBusy();
    runReset(19'h0_00FF);
    toBusEdge(); xferStartIn = 1; busBusy = 1; #1;
    check(startReq === 1'b0, "R8", "transfer seen", startReq, 0);
    toBusEdge(); xferStartIn = 0; busGnt = 1; #1;
    check(startReq === 1'b0, "R8", "busy held keeps waiting", startReq, 0);
    toBusEdge(); busBusy = 0; #1;
    check(startReq === 1'b0, "R9", "busy-fall edge with grant", startReq, 0);
    toBusEdge(); #1;
    check(startReq === 1'b1, "R8", "start after busy falls", startReq, 1);
  endtask

  task automatic testSameEdge();
    runReset(19'h6_5432);
    toBusEdge(); xferStartIn = 1; #1;
    toBusEdge(); xferStartIn = 0; tenureEnd = 1; busGnt = 1; #1;
    check(startReq === 1'b0, "R9", "tenure end and grant same edge", startReq, 0);
    toBusEdge(); tenureEnd = 0; #1;
    check(startReq === 1'b1, "R9", "start on following edge", startReq, 1);
  endtask

  task automatic testResetWhileWaiting();
    runReset(19'h4_4444);
    toBusEdge(); rstInN = 0; busGnt = 1; #1;
    check(startReq === 1'b0, "R10", "reset suppresses start", startReq, 0);
    @(negedge clk); #1;
    check(coreRst === 1'b1 && busOe === '0, "R10", "back in reset", {coreRst, busOe}, 5'h10);
    check(startCnt == 0, "R10", "no start counted", startCnt, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testResetState();
    testStrapsStretch();
    testGrantStart();
    testCfgAndReassert();
    testAltTenure();
    testAltBusy();
    testSameEdge();
    testResetWhileWaiting();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule